// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire serial audio stream (bit clock, frame clock, data) into parallel stereo samples. The bit clock and frame clock come from outside and are sampled by the system clock. A rising bit-clock edge is found by comparing each sample with the one taken a cycle earlier, and the data bit and frame-clock level are taken in that same cycle. Four framings are supported: left-justified, I²S, right-justified with a selectable word length, and a pulse-framed DSP mode that carries both channels back to back.

Every completed sample is put out as a 32-bit word, left-aligned, with its unused low bits cleared. A channel tag and a one-cycle valid strobe go with it. A loopback control lets the receiver take its serial input from the local transmit data line instead of the external pin, so a link can be tested without leaving the device. The system integrator sets the framing and length controls and holds them steady. Reset is applied before any change of mode.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it was low, `smp_valid` is 0, `smp_data` is zero and `smp_right` is 0.
- R2: With `dsp_en`=0 and `fmt`=00 (left-justified), the half-frame starts at the first bit-clock rise that sees a new frame-clock level. That bit is the MSB. Frame clock high marks the left channel. The first 24 bits are delivered in `smp_data[31:8]`, `smp_data[7:0]` is 0, and any later bits in that half-frame are ignored.
- R3: With `dsp_en`=0 and `fmt`=01 (I²S), the MSB is the bit one bit-clock after the frame-clock change, and frame clock low marks the left channel. There are 24 data bits, left-aligned, with the low byte zero.
- R4: With `dsp_en`=0 and `fmt`=10 (right-justified), frame clock high marks the left channel. The sample is the last N bits before the frame-clock change, where `wlen` 00/01/10/11 gives N = 24/20/18/16. It is delivered left-aligned with the low 32-N bits zero.
- R5: With `dsp_en`=1, whatever the value of `fmt`, a frame starts at a bit-clock rise where the frame clock goes from low to high. The left sample's MSB comes on the next bit. The right sample follows directly after the left sample's last bit. `wlen` 00/01/10/11 gives N = 32/24/20/16. Each sample is left-aligned, and its strobe comes one cycle after its last bit.
- R6: Each sample gives exactly one `smp_valid` pulse, lasting one cycle, on the cycle after the bit-clock rise that completes it. In edge-framed modes the word appears at the rise that begins the next half-frame. A half-frame already under way when reset ends gives no word, and DSP bits before the first frame pulse give no word.
- R7: With `dsp_en`=0 and `fmt`=11 (reserved), `smp_valid` never rises.
- R8: With `loop_en`=1 the serial input is `loop_sdata`, and `sdata_in` has no effect. With `loop_en`=0 the serial input is `sdata_in`, and `loop_sdata` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, synchronous to `clk` |
| fclk_in | input | 1 | Frame (word-select) clock, synchronous to `clk` |
| sdata_in | input | 1 | External serial data pin |
| loop_sdata | input | 1 | Local serial transmit data, used in loopback |
| loop_en | input | 1 | 1 selects `loop_sdata` as the serial input |
| dsp_en | input | 1 | 1 selects pulse-framed DSP mode |
| fmt | input | 2 | Framing: 00 left-justified, 01 I²S, 10 right-justified, 11 reserved |
| wlen | input | 2 | Word-length code for right-justified and DSP modes |
| smp_data | output | 32 | Received sample, left-aligned |
| smp_right | output | 1 | 1 = right-channel sample |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench fills the bit slots outside each capture window with random data. A receiver that captured past bit 24, or that took the wrong end of a right-justified half-frame, would therefore deliver garbage in the low bits or a shifted sample. Each mode begins with a half-frame (or DSP bits ahead of the first pulse) that must produce no word. A design that did not wait for a real frame boundary would emit an extra sample and break the count. DSP runs cover all four lengths, including 32 bits, where the right sample ends on bit-clock 64. A counter that was too narrow, or an off-by-one between the channels, would move the right word. Loopback runs drive random data on whichever line is unused, so a receiver wired to the wrong line would fail every word.

// File: rtl/aud_rx_pkg.sv
// Package: shared constants, framing codes and word-length decoding
// for the serial audio receiver.
package aud_rx_pkg;

    localparam int SAMPLE_W = 32;   // parallel output width
    localparam int STD_W    = 24;   // bits kept in left-justified / I2S modes

    typedef enum logic [1:0] {
        FMT_LEFTJ  = 2'b00,
        FMT_I2S    = 2'b01,
        FMT_RIGHTJ = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    // Right-justified sample length for a word-length code.
    function automatic logic [5:0] rj_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd24;
            2'b01:   return 6'd20;
            2'b10:   return 6'd18;
            default: return 6'd16;
        endcase
    endfunction

    // DSP-mode sample length for a word-length code.
    function automatic logic [5:0] dsp_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd32;
            2'b01:   return 6'd24;
            2'b10:   return 6'd20;
            default: return 6'd16;
        endcase
    endfunction

endpackage

// File: rtl/aud_rx_edge.sv
// Edge finder: detects rising bit-clock edges and frame-clock level
// changes seen at those edges.
// Assumes bclk and fclk are already synchronous to clk (no metastability
// filtering here) and that bclk stays high and low for at least one
// clk cycle each.
module aud_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fclk,
    output logic bit_stb,    // this cycle holds a bit-clock rise
    output logic frm_chg,    // frame clock differs from its level at the last rise
    output logic frm_rise    // frame clock went low to high at this rise
);

    logic bclk_q;
    logic fs_prev;
    logic primed;

    assign bit_stb  = bclk & ~bclk_q;
    assign frm_chg  = bit_stb & primed & (fclk != fs_prev);
    assign frm_rise = frm_chg & fclk;

    // Keep the last bit-clock sample and the frame level of the last rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            fs_prev <= 1'b0;
            primed  <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (bit_stb) begin
                fs_prev <= fclk;
                primed  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/aud_rx_bitpos.sv
// Bit position counter: numbers the bit-clock rises since the last frame
// start (the start rise itself is 0) and remembers whether any frame
// start has been seen since reset. The count saturates at its maximum.
module aud_rx_bitpos #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             start,
    output logic [CNT_W-1:0] cur_idx,  // index of the bit in this cycle
    output logic             locked    // a frame start happened before this rise
);

    logic [CNT_W-1:0] idx_q;

    // Index of the current bit: restart at a frame start, else step with saturation.
    always_comb begin
        if (start)
            cur_idx = '0;
        else if (idx_q == {CNT_W{1'b1}})
            cur_idx = idx_q;
        else
            cur_idx = idx_q + CNT_W'(1);
    end

    // Store the index and the lock flag at each bit-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            locked <= 1'b0;
        end else if (bit_stb) begin
            idx_q <= cur_idx;
            if (start)
                locked <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
// Multi-format serial audio receiver top.
// Turns a bit-clock / frame-clock / data stream into left-aligned
// 32-bit samples with a channel tag and a one-cycle valid strobe.
// Assumes fmt, wlen, dsp_en and loop_en stay steady between resets.
module serial_audio_rx
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                fclk_in,
    input  logic                sdata_in,
    input  logic                loop_sdata,
    input  logic                loop_en,
    input  logic                dsp_en,
    input  logic [1:0]          fmt,
    input  logic [1:0]          wlen,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic                smp_right,
    output logic                smp_valid
);

    localparam int PW = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0]    ONE     = CNT_W'(1);
    localparam logic [SAMPLE_W-1:0] TOP_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic             bit_stb, frm_chg, frm_rise, start, locked;
    logic [CNT_W-1:0] cur_idx;
    logic             sbit;
    fmt_e             mode;
    logic             is_std, is_rj, is_dsp;
    logic [5:0]       wl;

    logic [SAMPLE_W-1:0] shreg, cap_q, cap_next, mask, rj_word;
    logic                half_right_q;
    logic [CNT_W-1:0]    n_w, off_w, rel;
    logic                in_win, win_last, win_right;
    logic                emit_edge, emit_dsp;

    assign mode   = fmt_e'(fmt);
    assign is_dsp = dsp_en;
    assign is_rj  = !dsp_en && (mode == FMT_RIGHTJ);
    assign is_std = !dsp_en && ((mode == FMT_LEFTJ) || (mode == FMT_I2S));
    assign sbit   = loop_en ? loop_sdata : sdata_in;
    assign start  = is_dsp ? frm_rise : frm_chg;
    assign wl     = is_dsp ? dsp_bits(wlen) : rj_bits(wlen);

    aud_rx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk_in),
        .fclk     (fclk_in),
        .bit_stb  (bit_stb),
        .frm_chg  (frm_chg),
        .frm_rise (frm_rise)
    );

    aud_rx_bitpos #(.CNT_W(CNT_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb),
        .start   (start),
        .cur_idx (cur_idx),
        .locked  (locked)
    );

    // Find whether the current bit falls inside a capture window, and where.
    always_comb begin
        n_w       = CNT_W'(wl);
        off_w     = (mode == FMT_I2S) ? ONE : '0;
        rel       = '0;
        in_win    = 1'b0;
        win_last  = 1'b0;
        win_right = 1'b0;
        if (is_std) begin
            rel    = cur_idx - off_w;
            in_win = (cur_idx >= off_w) && (rel < CNT_W'(STD_W));
        end else if (is_dsp && locked) begin
            if ((cur_idx >= ONE) && (cur_idx <= n_w)) begin
                rel      = cur_idx - ONE;
                in_win   = 1'b1;
                win_last = (cur_idx == n_w);
            end else if ((cur_idx > n_w) && (cur_idx <= (n_w << 1))) begin
                rel       = cur_idx - n_w - ONE;
                in_win    = 1'b1;
                win_right = 1'b1;
                win_last  = (cur_idx == (n_w << 1));
            end
        end
    end

    // Merge the current bit into the left-aligned capture word.
    always_comb begin
        mask     = TOP_BIT >> rel[PW-1:0];
        cap_next = (start ? '0 : cap_q) | ((in_win && sbit) ? mask : '0);
        rj_word  = shreg << (6'(SAMPLE_W) - wl);
    end

    assign emit_edge = start && locked && (is_std || is_rj);
    assign emit_dsp  = bit_stb && in_win && win_last;

    // Shift history, capture word and half-frame channel, one step per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg        <= '0;
            cap_q        <= '0;
            half_right_q <= 1'b0;
        end else if (bit_stb) begin
            shreg <= {shreg[SAMPLE_W-2:0], sbit};
            cap_q <= emit_dsp ? '0 : cap_next;
            if (start)
                half_right_q <= (mode == FMT_I2S) ? fclk_in : ~fclk_in;
        end
    end

    // Register the outgoing sample, its tag and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_data  <= '0;
            smp_right <= 1'b0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= emit_edge || emit_dsp;
            if (emit_edge) begin
                smp_data  <= is_rj ? rj_word : cap_q;
                smp_right <= half_right_q;
            end else if (emit_dsp) begin
                smp_data  <= cap_next;
                smp_right <= win_right;
            end
        end
    end

endmodule

// File: rtl/aud_rx_sva.sv
// Assertion checker for serial_audio_rx, bound to every instance.
// Watches only top-level ports.
module aud_rx_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        bclk_in,
    input logic        dsp_en,
    input logic [1:0]  fmt,
    input logic [1:0]  wlen,
    input logic [31:0] smp_data,
    input logic        smp_valid
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!smp_valid && (smp_data == 32'h0)));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    assert_strobe_after_bclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ($past(bclk_in) && !$past(bclk_in, 2)));

    assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt) == 2'b11 && !$past(dsp_en)) |-> !smp_valid);

    assert_std_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !$past(dsp_en) && ($past(fmt) == 2'b00 || $past(fmt) == 2'b01))
        |-> (smp_data[7:0] == 8'h0));

    assert_rj16_low_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !$past(dsp_en) && $past(fmt) == 2'b10 && $past(wlen) == 2'b11)
        |-> (smp_data[15:0] == 16'h0));

endmodule

bind serial_audio_rx aud_rx_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_in   (bclk_in),
    .dsp_en    (dsp_en),
    .fmt       (fmt),
    .wlen      (wlen),
    .smp_data  (smp_data),
    .smp_valid (smp_valid)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0, fclk_in = 1'b0, sdata_in = 1'b0, loop_sdata = 1'b0;
    logic        loop_en = 1'b0, dsp_en = 1'b0;
    logic [1:0]  fmt = 2'b00, wlen = 2'b00;
    logic [31:0] smp_data;
    logic        smp_right, smp_valid;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  use_loop = 0;
    logic [31:0] exp_d[$], got_d[$];
    logic        exp_r[$], got_r[$];

    always #10 clk = ~clk;   // 50 MHz

    serial_audio_rx dut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fclk_in(fclk_in),
        .sdata_in(sdata_in), .loop_sdata(loop_sdata), .loop_en(loop_en),
        .dsp_en(dsp_en), .fmt(fmt), .wlen(wlen),
        .smp_data(smp_data), .smp_right(smp_right), .smp_valid(smp_valid)
    );

    // Collect every strobed sample, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            got_d.push_back(smp_data);
            got_r.push_back(smp_right);
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int rj_len(input logic [1:0] c);
        case (c) 2'b00: return 24; 2'b01: return 20; 2'b10: return 18; default: return 16; endcase
    endfunction

    function automatic int dsp_len(input logic [1:0] c);
        case (c) 2'b00: return 32; 2'b01: return 24; 2'b10: return 20; default: return 16; endcase
    endfunction

    function automatic logic [31:0] low_mask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bclk_in = 1'b0; fclk_in = 1'b0;
        repeat (3) @(negedge clk);
        got_d.delete(); got_r.delete(); exp_d.delete(); exp_r.delete();
        rst_n = 1'b1;
    endtask

    // One bit slot: two clocks with bclk low, then two with bclk high.
    task automatic send_bit(input logic fs, input logic b);
        @(negedge clk);
        bclk_in = 1'b0;
        fclk_in = fs;
        if (use_loop) begin loop_sdata = b; sdata_in = 1'($urandom); end
        else begin sdata_in = b; loop_sdata = 1'($urandom); end
        @(negedge clk);
        @(negedge clk);
        bclk_in = 1'b1;
        @(negedge clk);
    endtask

    // One 32-slot half-frame in an edge-framed mode; unused slots get random bits.
    task automatic send_half(input logic [1:0] f, input int n, input logic [31:0] w,
                             input bit left);
        logic fs;
        fs = (f == 2'b01) ? !left : left;
        for (int i = 0; i < 32; i++) begin
            logic b;
            b = 1'($urandom);
            if (f == 2'b01) begin
                if (i >= 1 && i <= 24) b = w[24-i];
            end else if (f == 2'b10) begin
                if (i >= 32 - n) b = w[31-i];
            end else begin
                if (i < 24) b = w[23-i];
            end
            send_bit(fs, b);
        end
    endtask

    task automatic finish_run(input string req);
        int n;
        repeat (8) @(negedge clk);
        check(got_d.size() == exp_d.size(), {req, " R6 sample count"},
              32'(got_d.size()), 32'(exp_d.size()));
        n = (got_d.size() < exp_d.size()) ? got_d.size() : exp_d.size();
        for (int i = 0; i < n; i++) begin
            check(got_d[i] == exp_d[i], {req, " data"}, got_d[i], exp_d[i]);
            check(got_r[i] == exp_r[i], {req, " channel"}, 32'(got_r[i]), 32'(exp_r[i]));
        end
    endtask

    // Edge-framed run: partial preamble, eight half-frames, trailing half.
    task automatic run_edge(input logic [1:0] f, input logic [1:0] wl, input bit lp,
                            input string req);
        int n;
        fmt = f; wlen = wl; dsp_en = 1'b0; loop_en = lp; use_loop = lp;
        do_reset();
        n = rj_len(wl);
        send_half(f, n, $urandom, 1'b0);
        for (int h = 0; h < 8; h++) begin
            logic [31:0] w;
            bit left;
            left = (h % 2 == 0);
            w = $urandom;
            if (f == 2'b10) w = w & low_mask(n);
            send_half(f, n, w, left);
            if (f != 2'b11) begin
                exp_d.push_back((f == 2'b10) ? (w << (32 - n)) : {w[23:0], 8'h00});
                exp_r.push_back(!left);
            end
        end
        send_half(f, n, $urandom, 1'b1);
        finish_run(req);
    endtask

    // DSP run: random bits before the first pulse, then pulse-framed pairs.
    task automatic run_dsp(input logic [1:0] wl, input int frames);
        int n;
        fmt = 2'($urandom); wlen = wl; dsp_en = 1'b1; loop_en = 1'b0; use_loop = 1'b0;
        do_reset();
        n = dsp_len(wl);
        for (int i = 0; i < 5; i++) send_bit(1'b0, 1'($urandom));
        for (int fr = 0; fr < frames; fr++) begin
            logic [31:0] lw, rw;
            lw = $urandom & low_mask(n);
            rw = $urandom & low_mask(n);
            send_bit(1'b1, 1'($urandom));
            for (int i = 0; i < n; i++) send_bit(1'b0, lw[n-1-i]);
            for (int i = 0; i < n; i++) send_bit(1'b0, rw[n-1-i]);
            for (int i = 0; i < 3; i++) send_bit(1'b0, 1'($urandom));
            exp_d.push_back(lw << (32 - n)); exp_r.push_back(1'b0);
            exp_d.push_back(rw << (32 - n)); exp_r.push_back(1'b1);
        end
        finish_run("R5");
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5A17);
        repeat (4) @(negedge clk);
        // R1: outputs quiet while in reset
        check(smp_valid == 1'b0, "R1 valid in reset", 32'(smp_valid), 0);
        check(smp_data == 32'h0, "R1 data in reset", smp_data, 0);
        check(smp_right == 1'b0, "R1 channel in reset", 32'(smp_right), 0);
        rst_n = 1'b1;

        run_edge(2'b00, 2'b00, 1'b0, "R2 left-justified");
        run_edge(2'b01, 2'b10, 1'b0, "R3 I2S");
        for (int c = 0; c < 4; c++) run_edge(2'b10, 2'(c), 1'b0, "R4 right-justified");
        for (int c = 0; c < 4; c++) run_dsp(2'(c), 3);
        run_edge(2'b11, 2'b00, 1'b0, "R7 reserved");
        run_edge(2'b00, 2'b01, 1'b1, "R8 loopback left-justified");
        run_edge(2'b10, 2'b11, 1'b1, "R8 loopback right-justified");
        for (int k = 0; k < 3; k++)
            run_edge(2'($urandom % 3), 2'($urandom), 1'($urandom), "R2 R3 R4 R8 random");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule